// File: doc/BRIEF.md
# Network Controller Command and Status Registers

This block is the register front end of a network interface controller. Software sees four word-addressed registers: a read-only status word, a command word that reads back what was last written, and a descriptor address that can be loaded as one 64-bit write or as two 32-bit halves. The block tracks four interrupt sources: command completion, packet received, transmit complete and software. Each source has its own pending flag and its own enable. The block also holds five receive-filter enables, a command-failed flag and a two-bit controller state. Its single interrupt line is the OR of every source that is both pending and enabled.

A command write does one of two things, chosen by its top bit. With the top bit at 0, it only clears pending flags and loads the enables and filters. With the top bit at 1, it does the same and also pushes the latched descriptor address into a small command queue. The control logic drains this queue through a valid/pop pair and reports each finished command with a done pulse and a pass/fail result. The packet datapath reports its events as one-cycle pulses.

Bus reads are registered: read data appears on the clock edge that samples the read strobe. Reading the status word has no side effects.

Top module: `nic_ctl_regs`

## Requirements
- R1: The status word holds the pending flags in bits 3:0 (bit 0 command completion, bit 1 packet received, bit 2 transmit complete, bit 3 software) and the four interrupt enables in bits 7:4 in the same order. It holds the filter enables in bits 12:8 (unicast, filtered multicast, broadcast, promiscuous, promiscuous multicast), the failed flag in bit 29 and the state in bits 31:30. Bits 28:13 always read zero.
- R2: In a write to the command register (address 1), a 1 in bit i of bits 3:0 clears pending flag i. A 0 in that bit leaves the flag unchanged.
- R3: Every command write loads the interrupt enables from bits 7:4 and the filter enables from bits 12:8, whatever the value of bit 31.
- R4: Reading the status register (address 0) changes no pending flag or other state.
- R5: A command write with bit 7 set also sets the software pending flag, and this takes priority over a clear in bit 3 of the same write.
- R6: A one-cycle pulse on `ev_done`, `ev_rx` or `ev_tx` sets pending flag 0, 1 or 2 and the flag holds until cleared. When a set and a clear hit the same flag in the same cycle, the set wins.
- R7: `irq` is high exactly when some source is both pending and enabled.
- R8: A read of the command register returns the last 32-bit value written to it.
- R9: At address 2, a write with `bus_wide` high loads the whole descriptor address from `bus_wdata`. With `bus_wide` low it loads only the low 32 bits. A write at address 3 loads the upper half from `bus_wdata[31:0]`. Reads of address 2 return the whole address.
- R10: A command write with bit 31 set pushes the current descriptor address into a first-in first-out queue of `CQ_DEPTH` entries. The queue presents the oldest entry on `cq_addr` with `cq_valid`, and `cq_pop` removes that entry.
- R11: An issue write while the queue is full is dropped and sets the failed flag. The queue contents stay unchanged.
- R12: A pulse on `ev_done` sets the command completion pending flag and loads the failed flag from `done_fail`. An overflow in the same cycle takes priority and sets the failed flag to 1.
- R13: The status state field is 3 (busy) whenever the queue holds an entry. Otherwise it equals `ctl_state` (0 stopped, 1 started, 2 initialized).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 command, 2 descriptor low/full, 3 descriptor high |
| bus_wide | input | 1 | Write at address 2 carries the full 64-bit address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| ev_rx | input | 1 | Packet received pulse |
| ev_tx | input | 1 | Transmit complete pulse |
| ev_done | input | 1 | Command finished pulse |
| done_fail | input | 1 | Result of the finished command, 1 on failure |
| ctl_state | input | 2 | Controller state from the control logic |
| cq_pop | input | 1 | Consume the oldest queued descriptor |
| cq_valid | output | 1 | Queue holds at least one descriptor |
| cq_addr | output | ADDR_W | Oldest queued descriptor address |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus carries at most one write or read per cycle and that event pulses last one cycle. They also assume `cq_pop` is only raised while `cq_valid` is high. The bench therefore drives every bus access and event as a single-cycle strobe, set and released on falling edges. It raises the pop only after it has seen `cq_valid` high and compared `cq_addr` with the expected entry. Overflow is exercised with no pop or done pulse in the same cycle, so the unchanged-queue check compares against a quiet previous cycle.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
   localparam int N_SRC  = 4;
   localparam int N_FILT = 5;

   localparam logic [1:0] A_STATUS = 2'd0;
   localparam logic [1:0] A_CMD    = 2'd1;
   localparam logic [1:0] A_DESC   = 2'd2;
   localparam logic [1:0] A_DESCHI = 2'd3;

   localparam int B_CLR_LO  = 0;
   localparam int B_EN_LO   = 4;
   localparam int B_SW_EN   = 7;
   localparam int B_FILT_LO = 8;
   localparam int B_FAIL    = 29;
   localparam int B_ISSUE   = 31;

   typedef enum logic [1:0] {
      ST_STOPPED = 2'd0,
      ST_STARTED = 2'd1,
      ST_INITED  = 2'd2,
      ST_BUSY    = 2'd3
   } ctl_state_e;
endpackage

// File: rtl/nic_irq_src.sv
module nic_irq_src #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n)          pend_o[i] <= 1'b0;
         else if (set_i[i])   pend_o[i] <= 1'b1;
         else if (clr_i[i])   pend_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/nic_cmd_q.sv
module nic_cmd_q #(
   parameter int W     = 64,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [W-1:0]     din_i,
   input  logic             pop_i,
   output logic [W-1:0]     dout_o,
   output logic             valid_o,
   output logic             full_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("nic_cmd_q: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full_o  = (cnt == CW'(DEPTH));
   assign valid_o = (cnt != '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && valid_o;
   assign dout_o  = mem[rp];
   assign count_o = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                          mem[e] <= '0;
         else if (do_push && wp == PW'(e))    mem[e] <= din_i;
      end
   end
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
   import nic_ctl_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int CQ_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wide,
   input  logic [63:0]       bus_wdata,
   output logic [63:0]       bus_rdata,
   input  logic              ev_rx,
   input  logic              ev_tx,
   input  logic              ev_done,
   input  logic              done_fail,
   input  logic [1:0]        ctl_state,
   input  logic              cq_pop,
   output logic              cq_valid,
   output logic [ADDR_W-1:0] cq_addr,
   output logic              irq
);
   localparam int HI_W = ADDR_W - 32;
   localparam int CW   = $clog2(CQ_DEPTH+1);

   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr
      $error("nic_ctl_regs: ADDR_W must lie in 33..64");
   end

   logic              cmd_wr, issue;
   logic [31:0]       cmd_q;
   logic [N_SRC-1:0]  irq_en, pend, set_v, clr_v;
   logic [N_FILT-1:0] filt;
   logic              fail;
   logic [ADDR_W-1:0] desc;
   logic              q_full;
   logic [CW-1:0]     q_cnt;
   logic [31:0]       status;

   assign cmd_wr = bus_wr && (bus_addr == A_CMD);
   assign issue  = cmd_wr && bus_wdata[B_ISSUE];

   // event sources in status order: done, rx, tx, software
   assign set_v = {cmd_wr && bus_wdata[B_SW_EN], ev_tx, ev_rx, ev_done};
   assign clr_v = cmd_wr ? bus_wdata[B_CLR_LO +: N_SRC] : '0;

   nic_irq_src #(.N(N_SRC)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .pend_o (pend)
   );

   nic_cmd_q #(.W(ADDR_W), .DEPTH(CQ_DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (issue),
      .din_i   (desc),
      .pop_i   (cq_pop),
      .dout_o  (cq_addr),
      .valid_o (cq_valid),
      .full_o  (q_full),
      .count_o (q_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         irq_en <= '0;
         filt   <= '0;
      end else if (cmd_wr) begin
         cmd_q  <= bus_wdata[31:0];
         irq_en <= bus_wdata[B_EN_LO +: N_SRC];
         filt   <= bus_wdata[B_FILT_LO +: N_FILT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                fail <= 1'b0;
      else if (issue && q_full)  fail <= 1'b1;
      else if (ev_done)          fail <= done_fail;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc <= '0;
      end else if (bus_wr && bus_addr == A_DESC) begin
         if (bus_wide) desc <= bus_wdata[ADDR_W-1:0];
         else          desc[31:0] <= bus_wdata[31:0];
      end else if (bus_wr && bus_addr == A_DESCHI) begin
         desc[ADDR_W-1:32] <= bus_wdata[HI_W-1:0];
      end
   end

   always_comb begin
      status = '0;
      status[B_CLR_LO +: N_SRC]   = pend;
      status[B_EN_LO +: N_SRC]    = irq_en;
      status[B_FILT_LO +: N_FILT] = filt;
      status[B_FAIL]              = fail;
      status[31:30]               = cq_valid ? ST_BUSY : ctl_state;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (bus_addr)
            A_STATUS: bus_rdata <= {32'b0, status};
            A_CMD:    bus_rdata <= {32'b0, cmd_q};
            A_DESC:   bus_rdata <= 64'(desc);
            default:  bus_rdata <= 64'(desc[ADDR_W-1:32]);
         endcase
      end
   end

   assign irq = |(pend & irq_en);
endmodule

// File: rtl/nic_ctl_regs_chk.sv
module nic_ctl_regs_chk #(
   parameter int CQ_DEPTH = 4,
   parameter int CW       = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [1:0]    bus_addr,
   input logic [63:0]   bus_wdata,
   input logic          ev_rx,
   input logic          ev_tx,
   input logic          ev_done,
   input logic          cq_pop,
   input logic [3:0]    pend,
   input logic          fail,
   input logic          q_full,
   input logic [CW-1:0] q_cnt,
   input logic [31:0]   status
);
   logic cmd_w;
   assign cmd_w = bus_wr && bus_addr == 2'd1;

   // R4: status read with no other activity leaves pending flags alone
   a_r4_read_pure: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && !ev_rx && !ev_tx && !ev_done) |=> $stable(pend));

   // R2: a clear bit with no competing set empties the flag
   a_r2_clear_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && bus_wdata[1] && !ev_rx) |=> !pend[1]);

   // R5: enabling software interrupts raises the software flag
   a_r5_sw_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && bus_wdata[7]) |=> pend[3]);

   // R11: overflow marks failure and leaves the queue untouched
   a_r11_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && bus_wdata[31] && q_full && !cq_pop) |=> (fail && $stable(q_cnt)));

   // R13: a non-empty queue reports busy
   a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt != '0) |-> (status[31:30] == 2'b11));

   // R10: occupancy never exceeds the depth
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CW'(CQ_DEPTH));

   // R1: reserved status bits stay zero
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status[28:13] == '0);
endmodule

bind nic_ctl_regs nic_ctl_regs_chk #(.CQ_DEPTH(CQ_DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ev_rx     (ev_rx),
   .ev_tx     (ev_tx),
   .ev_done   (ev_done),
   .cq_pop    (cq_pop),
   .pend      (pend),
   .fail      (fail),
   .q_full    (q_full),
   .q_cnt     (q_cnt),
   .status    (status)
);

// File: tb/sim_nic_ctl_regs.sv
module sim_nic_ctl_regs;
   localparam int CLK_P = 10;
   localparam int AW    = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic          ev_rx = 1'b0, ev_tx = 1'b0, ev_done = 1'b0, done_fail = 1'b0;
   logic [1:0]    ctl_state = 2'd0;
   logic          cq_pop = 1'b0;
   logic          cq_valid;
   logic [AW-1:0] cq_addr;
   logic          irq;

   int total = 0;
   int bad   = 0;
   logic [63:0] rv;

   always #(CLK_P/2) clk = ~clk;

   nic_ctl_regs #(.ADDR_W(AW), .CQ_DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_done(ev_done),
      .done_fail(done_fail), .ctl_state(ctl_state), .cq_pop(cq_pop),
      .cq_valid(cq_valid), .cq_addr(cq_addr), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic wide = 1'b0);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
      @(negedge clk);
      bus_wr = 1'b0; bus_wide = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      rv = bus_rdata;
   endtask

   task automatic t_reset();
      rd(2'd0); chk("R1 reset status", rv, 64'h0);
      rd(2'd1); chk("R8 reset command", rv, 64'h0);
      chk("R7 reset irq", 64'(irq), 64'h0);
      chk("R10 reset valid", 64'(cq_valid), 64'h0);
   endtask

   task automatic t_pending();
      ev_rx = 1'b1; ev_tx = 1'b1; @(negedge clk); ev_rx = 1'b0; ev_tx = 1'b0;
      rd(2'd0); chk("R6 events latched", rv, 64'h6);
      rd(2'd0); chk("R4 second read unchanged", rv, 64'h6);
      chk("R7 masked irq low", 64'(irq), 64'h0);
      wr(2'd1, 64'h60);
      rd(2'd0); chk("R3 enables mirrored", rv, 64'h66);
      chk("R7 irq high", 64'(irq), 64'h1);
      wr(2'd1, 64'h62);
      rd(2'd0); chk("R2 clear rx only", rv, 64'h64);
      wr(2'd1, 64'h64);
      rd(2'd0); chk("R2 clear tx", rv, 64'h60);
      chk("R7 irq low after clear", 64'(irq), 64'h0);
      rd(2'd1); chk("R8 readback", rv, 64'h64);
      // set and clear together
      ev_rx = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 64'h62;
      @(negedge clk); ev_rx = 1'b0; bus_wr = 1'b0;
      rd(2'd0); chk("R6 set wins over clear", rv, 64'h62);
      wr(2'd1, 64'h62);
      rd(2'd0); chk("R2 later clear", rv, 64'h60);
   endtask

   task automatic t_soft();
      wr(2'd1, 64'h80);
      rd(2'd0); chk("R5 software raise", rv, 64'h88);
      chk("R7 software irq", 64'(irq), 64'h1);
      wr(2'd1, 64'h88);
      rd(2'd0); chk("R5 raise beats clear", rv, 64'h88);
      wr(2'd1, 64'h08);
      rd(2'd0); chk("R2 software cleared", rv, 64'h0);
      chk("R7 irq off", 64'(irq), 64'h0);
   endtask

   task automatic t_filters();
      wr(2'd1, 64'h1F00);
      rd(2'd0); chk("R3 all filters", rv, 64'h1F00);
      wr(2'd1, 64'h0A00);
      rd(2'd0); chk("R3 filter pattern", rv, 64'h0A00);
      wr(2'd1, 64'h1FFF_E000);
      rd(2'd0); chk("R1 undefined bits zero", rv, 64'h0);
      rd(2'd1); chk("R8 readback wide value", rv, 64'h1FFF_E000);
   endtask

   task automatic t_desc();
      wr(2'd2, 64'h1122_3344_5566_7788, 1'b1);
      rd(2'd2); chk("R9 full write", rv, 64'h1122_3344_5566_7788);
      wr(2'd2, 64'hFFFF_FFFF_AAAA_BBBB);
      rd(2'd2); chk("R9 low half", rv, 64'h1122_3344_AAAA_BBBB);
      wr(2'd3, 64'h0000_0000_CCCC_DDDD);
      rd(2'd2); chk("R9 high half", rv, 64'hCCCC_DDDD_AAAA_BBBB);
   endtask

   task automatic t_queue();
      ctl_state = 2'd2;
      @(negedge clk);
      rd(2'd0); chk("R13 idle state", rv, 64'h8000_0000);
      for (int k = 0; k < 4; k++) begin
         wr(2'd2, {32'h0000_00A0 + 32'(k), 32'h1000 + 32'(k)}, 1'b1);
         wr(2'd1, 64'h8000_0000);
      end
      chk("R10 valid", 64'(cq_valid), 64'h1);
      rd(2'd0); chk("R13 busy", rv, 64'hC000_0000);
      wr(2'd2, 64'hDEAD_BEEF_0000_0000, 1'b1);
      wr(2'd1, 64'h8000_0000);
      rd(2'd0); chk("R11 overflow fails", rv, 64'hE000_0000);
      for (int k = 0; k < 4; k++) begin
         chk("R10 order", cq_addr, {32'h0000_00A0 + 32'(k), 32'h1000 + 32'(k)});
         cq_pop = 1'b1; @(negedge clk); cq_pop = 1'b0;
      end
      chk("R11 dropped entry absent", 64'(cq_valid), 64'h0);
      rd(2'd0); chk("R13 back to input state", rv, 64'hA000_0000);
   endtask

   task automatic t_done();
      done_fail = 1'b0; ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
      rd(2'd0); chk("R12 done pass", rv, 64'h8000_0001);
      done_fail = 1'b1; ev_done = 1'b1; @(negedge clk); ev_done = 1'b0; done_fail = 1'b0;
      rd(2'd0); chk("R12 done fail", rv, 64'hA000_0001);
      wr(2'd1, 64'h11);
      rd(2'd0); chk("R2 clear completion", rv, 64'hA000_0010);
      ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
      rd(2'd0); chk("R12 done with enable", rv, 64'h8000_0011);
      chk("R7 completion irq", 64'(irq), 64'h1);
   endtask

   initial begin
      #(CLK_P * 20000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pending();
      t_soft();
      t_filters();
      t_desc();
      t_queue();
      t_done();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule